// File: doc/BRIEF.md
# Multi-hybrid predictor selection logic

This block picks which of several component branch predictors is trusted for a given branch, and trains that choice once the branch resolves. Every entry of the branch table carries one 2-bit saturating selection counter per component. At lookup the entry's counters are read, the components whose counter sits at the top value 3 are marked, and a fixed priority (component 0 highest) picks one of them. That component's prediction, supplied from outside, is forwarded as the selected prediction.

On resolution the entry's counters are trained from a per-component correctness vector. If some component at the top value was right, every wrong component loses one step. Otherwise every right component gains one step. Because of this rule each entry always keeps at least one counter at 3. A flush input returns the whole table to its starting state in one cycle, which models the loss of history at a context switch. The component predictors themselves are not part of the block.

Top module: `hybrid_selector`

## Requirements
- R1: After reset every counter of every entry is 3, so for any lookup index top_mask_o is all ones and sel_comp_o is 0.
- R2: sel_comp_o is the binary index of the lowest-numbered component whose counter at the lookup entry equals 3; bit k of top_mask_o is 1 exactly when component k's counter equals 3.
- R3: sel_pred_o equals comp_pred_i[sel_comp_o] in the same cycle, with no register on the path.
- R4: On an update where at least one component with counter 3 has its correct bit set, every component whose correct bit is 0 is decremented by one, stopping at 0, and components whose correct bit is 1 keep their value.
- R5: On an update where no component with counter 3 has its correct bit set, every component whose correct bit is 1 is incremented by one, stopping at 3, and components whose correct bit is 0 keep their value.
- R6: Every entry has at least one counter equal to 3 at all times, so top_mask_o is never zero.
- R7: An update changes only the entry at upd_idx_i and is seen by lookups from the next cycle on; a lookup in the update cycle sees the old values.
- R8: flush_i sets every counter of every entry to 3 from the next cycle on and takes priority over an update in the same cycle.
- R9: With upd_valid_i and flush_i low, no counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Return all counters to 3 |
| lkp_idx_i | input | IDX_W | Entry read for selection |
| comp_pred_i | input | NUM_COMP | Taken prediction of each component, bit k for component k |
| sel_pred_o | output | 1 | Prediction of the chosen component |
| sel_comp_o | output | COMP_W | Index of the chosen component |
| top_mask_o | output | NUM_COMP | Components at counter value 3 for the lookup entry |
| upd_valid_i | input | 1 | Train the entry at upd_idx_i this cycle |
| upd_idx_i | input | IDX_W | Entry being trained |
| upd_correct_i | input | NUM_COMP | Bit k set when component k predicted the resolved branch correctly |

## Verification
The bench builds the block with four components and eight entries, so random update indices hit the same entry often and counters are driven down to 0 and back up to 3 within a few hundred cycles. Four components make ties among several top-valued counters common, which exercises every priority position, and with eight entries a full sweep of lookups after reset and after a flush costs only eight cycles. Directed sequences cover both training branches, both saturation limits and a flush that collides with an update.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_TOP = ctr_t'(2**CTR_W - 1);
  localparam ctr_t CTR_BOT = '0;
endpackage

// File: rtl/hs_prio_enc.sv
module hs_prio_enc #(
  parameter int W   = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          vld_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IW'(k);
    end
  end
  assign vld_o = |req_i;
endmodule

// File: rtl/hs_update_rule.sv
module hs_update_rule
  import hs_pkg::*;
#(
  parameter int NUM_COMP = 4
) (
  input  ctr_t [NUM_COMP-1:0] row_i,
  input  logic [NUM_COMP-1:0] correct_i,
  output ctr_t [NUM_COMP-1:0] row_o
);
  logic [NUM_COMP-1:0] top;
  logic                top_hit;

  for (genvar k = 0; k < NUM_COMP; k++) begin : g_top
    assign top[k] = (row_i[k] == CTR_TOP);
  end

  assign top_hit = |(top & correct_i);

  for (genvar k = 0; k < NUM_COMP; k++) begin : g_step
    always_comb begin
      row_o[k] = row_i[k];
      if (top_hit) begin
        if (!correct_i[k] && row_i[k] != CTR_BOT) row_o[k] = row_i[k] - ctr_t'(1);
      end else begin
        if (correct_i[k] && row_i[k] != CTR_TOP) row_o[k] = row_i[k] + ctr_t'(1);
      end
    end
  end
endmodule

// File: rtl/hs_ctr_bank.sv
module hs_ctr_bank
  import hs_pkg::*;
#(
  parameter int NUM_COMP = 4,
  parameter int ENTRIES  = 256,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  ctr_t [NUM_COMP-1:0] wr_row_i,
  input  logic [IDX_W-1:0]    rd_a_idx_i,
  output ctr_t [NUM_COMP-1:0] rd_a_row_o,
  input  logic [IDX_W-1:0]    rd_b_idx_i,
  output ctr_t [NUM_COMP-1:0] rd_b_row_o
);
  ctr_t [NUM_COMP-1:0] row_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        row_q[e] <= {NUM_COMP{CTR_TOP}};
      end else if (flush_i) begin
        row_q[e] <= {NUM_COMP{CTR_TOP}};
      end else if (wr_en_i && wr_idx_i == IDX_W'(e)) begin
        row_q[e] <= wr_row_i;
      end
    end
  end

  assign rd_a_row_o = row_q[rd_a_idx_i];
  assign rd_b_row_o = row_q[rd_b_idx_i];
endmodule

// File: rtl/hybrid_selector.sv
module hybrid_selector
  import hs_pkg::*;
#(
  parameter int NUM_COMP = 4,
  parameter int ENTRIES  = 256,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int COMP_W  = $clog2(NUM_COMP)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic [IDX_W-1:0]    lkp_idx_i,
  input  logic [NUM_COMP-1:0] comp_pred_i,
  output logic                sel_pred_o,
  output logic [COMP_W-1:0]   sel_comp_o,
  output logic [NUM_COMP-1:0] top_mask_o,
  input  logic                upd_valid_i,
  input  logic [IDX_W-1:0]    upd_idx_i,
  input  logic [NUM_COMP-1:0] upd_correct_i
);
  ctr_t [NUM_COMP-1:0] lkp_row;
  ctr_t [NUM_COMP-1:0] upd_row;
  ctr_t [NUM_COMP-1:0] upd_row_nxt;
  logic                any_top;

  hs_ctr_bank #(.NUM_COMP(NUM_COMP), .ENTRIES(ENTRIES)) i_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (upd_idx_i),
    .wr_row_i   (upd_row_nxt),
    .rd_a_idx_i (lkp_idx_i),
    .rd_a_row_o (lkp_row),
    .rd_b_idx_i (upd_idx_i),
    .rd_b_row_o (upd_row)
  );

  hs_update_rule #(.NUM_COMP(NUM_COMP)) i_rule (
    .row_i     (upd_row),
    .correct_i (upd_correct_i),
    .row_o     (upd_row_nxt)
  );

  for (genvar k = 0; k < NUM_COMP; k++) begin : g_mask
    assign top_mask_o[k] = (lkp_row[k] == CTR_TOP);
  end

  hs_prio_enc #(.W(NUM_COMP)) i_prio (
    .req_i (top_mask_o),
    .idx_o (sel_comp_o),
    .vld_o (any_top)
  );

  assign sel_pred_o = any_top & comp_pred_i[sel_comp_o];
endmodule

// File: rtl/hs_checker.sv
module hs_checker
  import hs_pkg::*;
#(
  parameter int NUM_COMP = 4,
  parameter int IDX_W    = 8,
  parameter int COMP_W   = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                flush_i,
  input logic [NUM_COMP-1:0] comp_pred_i,
  input logic                sel_pred_o,
  input logic [COMP_W-1:0]   sel_comp_o,
  input logic [NUM_COMP-1:0] top_mask_o,
  input logic                upd_valid_i,
  input logic [IDX_W-1:0]    upd_idx_i,
  input ctr_t [NUM_COMP-1:0] upd_row
);
  ctr_t [NUM_COMP-1:0] prev_row_q;
  logic [IDX_W-1:0]    prev_idx_q;
  logic                prev_quiet_q;
  logic                prev_upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_row_q   <= '0;
      prev_idx_q   <= '0;
      prev_quiet_q <= 1'b0;
      prev_upd_q   <= 1'b0;
    end else begin
      prev_row_q   <= upd_row;
      prev_idx_q   <= upd_idx_i;
      prev_quiet_q <= !upd_valid_i && !flush_i;
      prev_upd_q   <= upd_valid_i && !flush_i;
    end
  end

  function automatic logic lower_clear(logic [NUM_COMP-1:0] m, logic [COMP_W-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < NUM_COMP; k++) if (k < int'(w) && m[k]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic small_step(ctr_t [NUM_COMP-1:0] a, ctr_t [NUM_COMP-1:0] b);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < NUM_COMP; k++) begin
      if (int'(a[k]) - int'(b[k]) > 1 || int'(b[k]) - int'(a[k]) > 1) ok = 1'b0;
    end
    return ok;
  endfunction

  p_one_at_max_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_mask_o != '0);

  p_winner_prio_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_mask_o[sel_comp_o] && lower_clear(top_mask_o, sel_comp_o));

  p_pred_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_pred_o == comp_pred_i[sel_comp_o]);

  p_flush_all_top_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (&top_mask_o));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_quiet_q && prev_idx_q == upd_idx_i) |-> upd_row == prev_row_q);

  p_unit_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_upd_q && prev_idx_q == upd_idx_i) |-> small_step(prev_row_q, upd_row));
endmodule

bind hybrid_selector hs_checker #(
  .NUM_COMP (NUM_COMP),
  .IDX_W    (IDX_W),
  .COMP_W   (COMP_W)
) i_hs_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flush_i     (flush_i),
  .comp_pred_i (comp_pred_i),
  .sel_pred_o  (sel_pred_o),
  .sel_comp_o  (sel_comp_o),
  .top_mask_o  (top_mask_o),
  .upd_valid_i (upd_valid_i),
  .upd_idx_i   (upd_idx_i),
  .upd_row     (upd_row)
);

// File: tb/test_hybrid_selector.sv
module test_hybrid_selector;
  localparam int C  = 4;
  localparam int N  = 8;
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(C);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic [IW-1:0] lkp_idx = '0;
  logic [C-1:0]  comp_pred = '0;
  logic          sel_pred;
  logic [CW-1:0] sel_comp;
  logic [C-1:0]  top_mask;
  logic          upd_valid = 1'b0;
  logic [IW-1:0] upd_idx = '0;
  logic [C-1:0]  upd_correct = '0;

  int mdl [N][C];
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hybrid_selector #(.NUM_COMP(C), .ENTRIES(N)) i_hybrid_selector (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .flush_i       (flush),
    .lkp_idx_i     (lkp_idx),
    .comp_pred_i   (comp_pred),
    .sel_pred_o    (sel_pred),
    .sel_comp_o    (sel_comp),
    .top_mask_o    (top_mask),
    .upd_valid_i   (upd_valid),
    .upd_idx_i     (upd_idx),
    .upd_correct_i (upd_correct)
  );

  function automatic logic [C-1:0] exp_mask(int e);
    logic [C-1:0] m;
    for (int k = 0; k < C; k++) m[k] = (mdl[e][k] == 3);
    return m;
  endfunction

  function automatic int exp_win(logic [C-1:0] m);
    for (int k = 0; k < C; k++) if (m[k]) return k;
    return 0;
  endfunction

  task automatic model_update(int e, logic [C-1:0] corr);
    logic [C-1:0] m;
    bit hit;
    m = exp_mask(e);
    hit = |(m & corr);
    for (int k = 0; k < C; k++) begin
      if (hit && !corr[k] && mdl[e][k] > 0) mdl[e][k]--;
      if (!hit && corr[k] && mdl[e][k] < 3) mdl[e][k]++;
    end
  endtask

  task automatic model_flush();
    for (int e = 0; e < N; e++) for (int k = 0; k < C; k++) mdl[e][k] = 3;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare lookup outputs for the entry currently on lkp_idx
  task automatic check_lookup(string req);
    logic [C-1:0] m;
    int w;
    m = exp_mask(int'(lkp_idx));
    w = exp_win(m);
    check(req, int'(top_mask), int'(m));
    check(req, int'(sel_comp), w);
    check("R3", int'(sel_pred), int'(comp_pred[w]));
  endtask

  // one cycle: drive at negedge, check old state, then clock
  task automatic cycle(bit fl, bit uv, int ui, logic [C-1:0] uc, int li,
                       logic [C-1:0] cp, string req);
    @(negedge clk);
    flush = fl; upd_valid = uv; upd_idx = IW'(ui); upd_correct = uc;
    lkp_idx = IW'(li); comp_pred = cp;
    #1;
    check_lookup(req);
    @(posedge clk);
    if (fl) model_flush();
    else if (uv) model_update(ui, uc);
  endtask

  task automatic idle_look(int li, logic [C-1:0] cp, string req);
    cycle(1'b0, 1'b0, 0, '0, li, cp, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5e1ec7));
    model_flush();
    #20 rst_n = 1'b1;

    // R1: every entry at top after reset
    for (int e = 0; e < N; e++) idle_look(e, 4'b1110, "R1");

    // R4: comp0 right at top -> others down; lookup in same cycle sees old (R7)
    cycle(1'b0, 1'b1, 2, 4'b0001, 2, 4'b0001, "R7");
    idle_look(2, 4'b0001, "R4");        // mask 0001
    idle_look(3, 4'b0000, "R7");        // neighbour untouched
    // R5: top comp0 wrong, 1 and 2 right -> up
    cycle(1'b0, 1'b1, 2, 4'b0110, 2, 4'b0010, "R4");
    idle_look(2, 4'b0010, "R5");        // mask 0111
    // R2: comp1 right among top -> winner 1
    cycle(1'b0, 1'b1, 2, 4'b0010, 2, 4'b0100, "R5");
    idle_look(2, 4'b0010, "R2");        // mask 0010, winner 1
    idle_look(2, 4'b1101, "R3");
    // R9: update valid low with correctness set leaves entry as is
    cycle(1'b0, 1'b0, 2, 4'b1111, 2, 4'b0000, "R9");
    idle_look(2, 4'b0000, "R9");

    // R4 saturation at 0
    for (int i = 0; i < 5; i++) cycle(1'b0, 1'b1, 5, 4'b1000, 5, 4'b1000, "R4");
    idle_look(5, 4'b1000, "R4");        // only comp3 at top, winner 3
    // R5 saturation at 3 and no change when nobody is right
    cycle(1'b0, 1'b1, 5, 4'b0000, 5, 4'b0000, "R5");
    for (int i = 0; i < 5; i++) cycle(1'b0, 1'b1, 5, 4'b0001, 5, 4'b0001, "R5");
    idle_look(5, 4'b0001, "R6");

    // R8: flush wins over a concurrent update
    cycle(1'b1, 1'b1, 2, 4'b0001, 0, 4'b0000, "R8");
    for (int e = 0; e < N; e++) idle_look(e, 4'b0101, "R8");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bit fl;
      bit uv;
      int ui;
      int li;
      fl = ($urandom_range(0, 199) == 0);
      uv = ($urandom_range(0, 3) != 0);
      ui = $urandom_range(0, N - 1);
      li = ($urandom_range(0, 1) == 0) ? ui : $urandom_range(0, N - 1);
      cycle(fl, uv, ui, C'($urandom), li, C'($urandom), "R2");
    end
    for (int e = 0; e < N; e++) idle_look(e, C'($urandom), "R6");

    finish_run();
  end
endmodule